// File: doc/BRIEF.md
# SPI Bus Sniffer with Escaped Stream Output

This block listens passively to a four-wire SPI bus (serial clock, controller-out data, controller-in data and an active-low select) and turns what it sees into a byte stream for a host. Each bus line is brought into the system clock domain through a synchroniser. The active clock edge is then found on the synchronised clock, using the configured idle level and phase. Whole bytes are collected on both data lines. Each collected byte is sent as an escaped record, and select transitions are sent as bracket markers.

The host starts a session with a single command byte. That byte also selects which traffic is recorded: all of it, only traffic while select is low, or only traffic while select is high. Any further host byte ends the session, and the block answers with 0x01. The encoded stream goes through a block-RAM FIFO to a ready/valid transmit port. If the stream backs up, the FIFO can overflow. An overflow raises a sticky flag and stops all further writes until the next session starts.

Top module: `spi_sniffer`

## Requirements
- R1: After reset, `tx_valid`, `overflow` and `sniffing` are all 0.
- R2: While idle, host byte 0x0D starts a session that records all traffic. 0x0E starts one that records only while `bus_cs_n` is low, and 0x0F starts one that records only while `bus_cs_n` is high. Any other host byte received while idle is ignored and produces no output.
- R3: While a session runs, any host byte ends it (`sniffing` falls on the next cycle) and queues the single reply byte 0x01.
- R4: During a session, every falling edge of `bus_cs_n` emits 0x5B and every rising edge emits 0x5D, whatever the filter.
- R5: Each recorded bus byte emits six bytes in this order: 0x5C, the MOSI byte, 0x28, 0x5C, the MISO byte, 0x29. Bits are assembled MSB first.
- R6: `cfg_cpol` gives the clock idle level. With `cfg_cpha`=0 the data are sampled on the leading edge (idle to active); with `cfg_cpha`=1 they are sampled on the trailing edge.
- R7: Clock edges outside the selected select level are not counted. The bit counter restarts at every `bus_cs_n` transition, so a partial byte before a transition is discarded.
- R8: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` and `tx_data` hold.
- R9: A stream byte that finds the FIFO full sets `overflow`. The flag stays set and no further stream byte is written until a new session starts, which clears it. The 0x01 reply is written only if there is room.
- R10: Capture keeps up with a bus clock whose high and low phases each last at least two system clock cycles (10 MHz bus against a 50 MHz system clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host byte strobe, one cycle per byte |
| host_data | input | 8 | Host byte |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| bus_sclk | input | 1 | Observed serial clock |
| bus_mosi | input | 1 | Observed controller-out data |
| bus_miso | input | 1 | Observed controller-in data |
| bus_cs_n | input | 1 | Observed active-low select |
| tx_valid | output | 1 | Stream byte available |
| tx_data | output | 8 | Stream byte |
| tx_ready | input | 1 | Host accepts the stream byte |
| overflow | output | 1 | Sticky FIFO overflow flag |
| sniffing | output | 1 | A session is running |

## Verification
The assertions assume that the host strobes `host_valid` for a single cycle per byte. They also assume that `cfg_cpol` and `cfg_cpha` change only while no session runs, and that `bus_sclk` rests at its idle level when a session starts. The stimulus keeps to these rules: it parks the clock at the new idle level and waits several cycles before sending a start command. It keeps each clock phase at two system cycles. It spaces select transitions and byte boundaries far enough apart that a six-byte record is finished before the next event is reported.

// File: rtl/spi_snf_pkg.sv
package spi_snf_pkg;
  typedef enum logic [1:0] {
    FLT_ALL  = 2'd0,
    FLT_LOW  = 2'd1,
    FLT_HIGH = 2'd2
  } filt_e;

  localparam logic [7:0] CMD_ALL  = 8'h0D;
  localparam logic [7:0] CMD_LOW  = 8'h0E;
  localparam logic [7:0] CMD_HIGH = 8'h0F;
  localparam logic [7:0] CH_OPEN  = 8'h5B;
  localparam logic [7:0] CH_CLOSE = 8'h5D;
  localparam logic [7:0] CH_ESC   = 8'h5C;
  localparam logic [7:0] CH_LPAR  = 8'h28;
  localparam logic [7:0] CH_RPAR  = 8'h29;
  localparam logic [7:0] CH_ACK   = 8'h01;
endpackage

// File: rtl/spi_snf_sync.sv
module spi_snf_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= RST_VAL;
    else     st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[i] <= RST_VAL;
      else     st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_snf_capture.sv
module spi_snf_capture
  import spi_snf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  filt_e         filt,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          sclk,
  input  logic          mosi,
  input  logic          miso,
  input  logic          cs_n,
  output logic          byte_stb,
  output logic [DW-1:0] mosi_byte,
  output logic [DW-1:0] miso_byte,
  output logic          cs_fall,
  output logic          cs_rise
);
  localparam int CW = $clog2(DW);

  logic          sclk_d, cs_d;
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] sh_mo, sh_mi;
  logic          samp_lvl, samp_edge, pass, cs_chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk;
      cs_d   <= cs_n;
    end
  end

  always_comb begin
    samp_lvl  = cpol ^ ~cpha;
    samp_edge = (sclk != sclk_d) && (sclk == samp_lvl);
    cs_chg    = (cs_n != cs_d);
    unique case (filt)
      FLT_LOW:  pass = ~cs_n;
      FLT_HIGH: pass = cs_n;
      default:  pass = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      bit_cnt   <= '0;
      sh_mo     <= '0;
      sh_mi     <= '0;
      byte_stb  <= 1'b0;
      cs_fall   <= 1'b0;
      cs_rise   <= 1'b0;
      mosi_byte <= '0;
      miso_byte <= '0;
    end else begin
      byte_stb <= 1'b0;
      cs_fall  <= cs_d & ~cs_n;
      cs_rise  <= ~cs_d & cs_n;
      if (cs_chg) begin
        bit_cnt <= '0;
      end else if (samp_edge && pass) begin
        sh_mo <= {sh_mo[DW-2:0], mosi};
        sh_mi <= {sh_mi[DW-2:0], miso};
        if (bit_cnt == CW'(DW-1)) begin
          bit_cnt   <= '0;
          byte_stb  <= 1'b1;
          mosi_byte <= {sh_mo[DW-2:0], mosi};
          miso_byte <= {sh_mi[DW-2:0], miso};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_snf_fifo.sv
module spi_snf_fifo #(
  parameter int DW = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          rd_fire;

  assign full    = (count == (AW+1)'(DEPTH));
  assign rd_fire = (count != '0) && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
    if (rd_fire) out_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (wr_en)   wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (rd_fire) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + (AW+1)'(wr_en) - (AW+1)'(rd_fire);
      if (rd_fire)        out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_sniffer.sv
module spi_sniffer
  import spi_snf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_valid,
  input  logic [7:0] host_data,
  input  logic       cfg_cpol,
  input  logic       cfg_cpha,
  input  logic       bus_sclk,
  input  logic       bus_mosi,
  input  logic       bus_miso,
  input  logic       bus_cs_n,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  output logic       overflow,
  output logic       sniffing
);
  localparam int BW = 8;

  logic [3:0]    raw, syn;
  logic          byte_stb, cs_fall, cs_rise;
  logic [BW-1:0] mo_byte, mi_byte, lat_mo, lat_mi;
  filt_e         filt;
  logic          pend_byte, pend_open, pend_close, seq_on;
  logic [2:0]    step;
  logic          push, reply, full, wr_en, is_cmd;
  logic [BW-1:0] pdata;

  assign raw = {bus_sclk, bus_mosi, bus_miso, bus_cs_n};

  spi_snf_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  spi_snf_capture #(.DW(BW)) u_cap (
    .clk(clk), .rst(rst), .en(sniffing), .filt(filt),
    .cpol(cfg_cpol), .cpha(cfg_cpha),
    .sclk(syn[3]), .mosi(syn[2]), .miso(syn[1]), .cs_n(syn[0]),
    .byte_stb(byte_stb), .mosi_byte(mo_byte), .miso_byte(mi_byte),
    .cs_fall(cs_fall), .cs_rise(cs_rise)
  );

  assign is_cmd = (host_data == CMD_ALL) || (host_data == CMD_LOW) ||
                  (host_data == CMD_HIGH);

  // Emission priority: running record, new record, close marker, open marker.
  always_comb begin
    push  = 1'b0;
    reply = 1'b0;
    pdata = '0;
    if (sniffing && host_valid) begin
      push  = 1'b1;
      reply = 1'b1;
      pdata = CH_ACK;
    end else if (sniffing) begin
      if (seq_on) begin
        push = 1'b1;
        unique case (step)
          3'd1:    pdata = lat_mo;
          3'd2:    pdata = CH_LPAR;
          3'd3:    pdata = CH_ESC;
          3'd4:    pdata = lat_mi;
          default: pdata = CH_RPAR;
        endcase
      end else if (pend_byte) begin
        push  = 1'b1;
        pdata = CH_ESC;
      end else if (pend_close) begin
        push  = 1'b1;
        pdata = CH_CLOSE;
      end else if (pend_open) begin
        push  = 1'b1;
        pdata = CH_OPEN;
      end
    end
  end

  assign wr_en = push && !full && (reply || !overflow);

  always_ff @(posedge clk) begin
    if (rst) begin
      sniffing   <= 1'b0;
      overflow   <= 1'b0;
      filt       <= FLT_ALL;
      pend_byte  <= 1'b0;
      pend_open  <= 1'b0;
      pend_close <= 1'b0;
      seq_on     <= 1'b0;
      step       <= '0;
      lat_mo     <= '0;
      lat_mi     <= '0;
    end else if (!sniffing) begin
      if (host_valid && is_cmd) begin
        sniffing   <= 1'b1;
        overflow   <= 1'b0;
        pend_byte  <= 1'b0;
        pend_open  <= 1'b0;
        pend_close <= 1'b0;
        seq_on     <= 1'b0;
        unique case (host_data)
          CMD_LOW:  filt <= FLT_LOW;
          CMD_HIGH: filt <= FLT_HIGH;
          default:  filt <= FLT_ALL;
        endcase
      end
    end else if (host_valid) begin
      sniffing   <= 1'b0;
      seq_on     <= 1'b0;
      pend_byte  <= 1'b0;
      pend_open  <= 1'b0;
      pend_close <= 1'b0;
    end else begin
      if (push && full) overflow <= 1'b1;
      if (seq_on) begin
        step <= step + 1'b1;
        if (step == 3'd5) seq_on <= 1'b0;
      end else if (pend_byte) begin
        pend_byte <= 1'b0;
        seq_on    <= 1'b1;
        step      <= 3'd1;
      end else if (pend_close) begin
        pend_close <= 1'b0;
      end else if (pend_open) begin
        pend_open <= 1'b0;
      end
      if (byte_stb) begin
        pend_byte <= 1'b1;
        lat_mo    <= mo_byte;
        lat_mi    <= mi_byte;
      end
      if (cs_fall) pend_open  <= 1'b1;
      if (cs_rise) pend_close <= 1'b1;
    end
  end

  spi_snf_fifo #(.DW(BW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(pdata), .full(full),
    .out_valid(tx_valid), .out_data(tx_data), .out_ready(tx_ready)
  );
endmodule

// File: rtl/spi_sniffer_chk.sv
module spi_sniffer_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_valid,
  input logic [7:0] host_data,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       overflow,
  input logic       sniffing
);
  logic start_cmd;
  assign start_cmd = (host_data == 8'h0D) || (host_data == 8'h0E) ||
                     (host_data == 8'h0F);

  p_tx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  p_stop_r3: assert property (@(posedge clk) disable iff (rst)
    sniffing && host_valid |=> !sniffing);

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    !sniffing && host_valid && start_cmd |=> sniffing && !overflow);

  p_ignore_r2: assert property (@(posedge clk) disable iff (rst)
    !sniffing && host_valid && !start_cmd |=> !sniffing);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    overflow && !host_valid |=> overflow);

  p_idle_no_ovf_r9: assert property (@(posedge clk) disable iff (rst)
    !sniffing && !overflow |=> !overflow);
endmodule

bind spi_sniffer spi_sniffer_chk u_chk (
  .clk(clk), .rst(rst), .host_valid(host_valid), .host_data(host_data),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
  .overflow(overflow), .sniffing(sniffing)
);

// File: tb/spi_sniffer_tb.sv
module spi_sniffer_tb;
  localparam int DEPTH = 16;
  localparam int HALF  = 2;

  typedef struct packed {
    logic [7:0] cmd;
    logic       cpol;
    logic       cpha;
    logic       frame_low;
    logic [7:0] mo;
    logic [7:0] mi;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'h0D, 1'b0, 1'b0, 1'b1, 8'hA5, 8'h3C},
    '{8'h0D, 1'b1, 1'b1, 1'b1, 8'h5C, 8'h28},
    '{8'h0E, 1'b0, 1'b1, 1'b1, 8'h00, 8'hFF},
    '{8'h0E, 1'b1, 1'b0, 1'b1, 8'h81, 8'h7E},
    '{8'h0E, 1'b0, 1'b0, 1'b0, 8'h12, 8'h34},
    '{8'h0F, 1'b0, 1'b0, 1'b0, 8'hC3, 8'h96},
    '{8'h0F, 1'b1, 1'b1, 1'b1, 8'hAA, 8'h55},
    '{8'h0D, 1'b1, 1'b0, 1'b0, 8'h5D, 8'h5B}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_valid = 1'b0;
  logic [7:0] host_data = '0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic bus_sclk = 1'b0, bus_mosi = 1'b0, bus_miso = 1'b0, bus_cs_n = 1'b1;
  logic tx_valid, tx_ready = 1'b1, overflow, sniffing;
  logic [7:0] tx_data;

  always #10 clk = ~clk;

  spi_sniffer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_data(host_data),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .bus_sclk(bus_sclk),
    .bus_mosi(bus_mosi), .bus_miso(bus_miso), .bus_cs_n(bus_cs_n),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .overflow(overflow), .sniffing(sniffing)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] rx [64];
  int rx_n = 0;
  logic [7:0] ex [64];
  int ex_n = 0;

  always @(negedge clk)
    if (tx_valid && tx_ready && rx_n < 64) begin
      rx[rx_n] = tx_data;
      rx_n = rx_n + 1;
    end

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host(input logic [7:0] b);
    @(negedge clk);
    host_valid = 1'b1;
    host_data  = b;
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic spi_bits(input logic [7:0] mo, input logic [7:0] mi, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      if (!cfg_cpha) begin
        bus_mosi = mo[i]; bus_miso = mi[i];
        cyc(HALF); bus_sclk = ~cfg_cpol;
        cyc(HALF); bus_sclk = cfg_cpol;
      end else begin
        bus_sclk = ~cfg_cpol; bus_mosi = mo[i]; bus_miso = mi[i];
        cyc(HALF); bus_sclk = cfg_cpol;
        cyc(HALF);
      end
    end
  endtask

  task automatic add(input logic [7:0] b);
    ex[ex_n] = b;
    ex_n++;
  endtask

  task automatic add_rec(input logic [7:0] mo, input logic [7:0] mi);
    add(8'h5C); add(mo); add(8'h28); add(8'h5C); add(mi); add(8'h29);
  endtask

  task automatic compare(input string req);
    chk({req, " length"}, rx_n, ex_n);
    for (int i = 0; i < ex_n && i < rx_n; i++) chk(req, rx[i], ex[i]);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] held;
    bit cap;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1: reset state
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 sniffing", sniffing, 0);

    // R2: non-command byte while idle is ignored
    host(8'h42);
    cyc(20);
    chk("R2 idle ignore sniffing", sniffing, 0);
    chk("R2 idle ignore output", rx_n, 0);

    // Table walk: R4 R5 R6 R7 R10 with R3 stop
    for (int v = 0; v < 8; v++) begin
      cfg_cpol = VEC[v].cpol; cfg_cpha = VEC[v].cpha;
      bus_sclk = VEC[v].cpol;
      cyc(6);
      rx_n = 0; ex_n = 0;
      host(VEC[v].cmd);
      chk("R2 start", sniffing, 1);
      cyc(6);
      if (VEC[v].frame_low) begin bus_cs_n = 1'b0; cyc(4); end
      spi_bits(VEC[v].mo, VEC[v].mi, 8);
      cyc(4);
      if (VEC[v].frame_low) bus_cs_n = 1'b1;
      cyc(20);
      host(8'h33);
      chk("R3 stop", sniffing, 0);
      cyc(40);
      cap = (VEC[v].cmd == 8'h0D) ||
            (VEC[v].cmd == 8'h0E && VEC[v].frame_low) ||
            (VEC[v].cmd == 8'h0F && !VEC[v].frame_low);
      if (VEC[v].frame_low) add(8'h5B);
      if (cap) add_rec(VEC[v].mo, VEC[v].mi);
      if (VEC[v].frame_low) add(8'h5D);
      add(8'h01);
      compare("R5 R4 R7 R3 vector");
    end

    // R7: partial byte discarded at select transition
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; bus_sclk = 1'b0;
    cyc(6);
    rx_n = 0; ex_n = 0;
    host(8'h0D);
    cyc(6);
    bus_cs_n = 1'b0; cyc(4);
    spi_bits(8'hF0, 8'h0F, 4);
    cyc(4); bus_cs_n = 1'b1; cyc(10);
    bus_cs_n = 1'b0; cyc(10);
    spi_bits(8'h96, 8'h69, 8);
    cyc(4); bus_cs_n = 1'b1; cyc(20);
    host(8'h00);
    cyc(40);
    add(8'h5B); add(8'h5D); add(8'h5B); add_rec(8'h96, 8'h69); add(8'h5D); add(8'h01);
    compare("R7 restart count");

    // R9 / R8: overflow with a stalled transmit port
    rx_n = 0;
    tx_ready = 1'b0;
    host(8'h0D);
    cyc(6);
    bus_cs_n = 1'b0; cyc(4);
    for (int k = 0; k < 3; k++) begin
      spi_bits(8'h11 * (k + 1), 8'hEE, 8);
      cyc(10);
    end
    bus_cs_n = 1'b1; cyc(20);
    chk("R9 overflow set", overflow, 1);
    held = tx_data;
    cyc(5);
    chk("R8 valid held", tx_valid, 1);
    chk("R8 data held", tx_data, held);
    host(8'h01);
    cyc(5);
    chk("R9 sticky after stop", overflow, 1);
    tx_ready = 1'b1;
    cyc(40);
    chk("R9 stored count", rx_n, DEPTH + 1);
    chk("R9 first byte", rx[0], 8'h5B);
    chk("R9 still set", overflow, 1);
    rx_n = 0;
    host(8'h0F);
    cyc(2);
    chk("R9 cleared on restart", overflow, 0);
    host(8'h77);
    cyc(20);
    chk("R3 reply count", rx_n, 1);
    chk("R3 reply value", rx[0], 8'h01);

    finish_run();
  end
endmodule